// File: doc/BRIEF.md
# Ring-Fed DMA Command Decoder

This block reads 32-bit command words out of a circular buffer in memory and turns them into actions for the rest of a DMA engine. Software places packets in the ring, then moves the write pointer forward. While the ring is switched on, the decoder fetches one word at a time through a single-outstanding memory read port. It parses each packet header and drives a one-cycle pulse on one of three outputs: a copy request (40-bit destination, 40-bit source, byte count), a register write (dword address, byte enables, data) or a trap interrupt.

The header word carries an opcode in bits 31:28 and a 20-bit count in bits 19:0. Every opcode has a fixed length. The only exception is the memory-write packet, whose length depends on the count. Opcodes that this block does not act on are still recognised, and the decoder steps over them using their length, so the ring stays aligned. An unknown opcode stops the engine until software turns the ring off. The read pointer moves only at whole-packet boundaries, so software always sees a consistent consumption point. A one-cycle writeback pulse can optionally mark each pointer update.

A five-entry configuration write port sets the ring control, ring base, read pointer, write pointer and engine control registers.

Top module: `dma_ring_decoder`

## Requirements
- R1: Words are fetched only while ring control bit 0 (enable) is set, no error is latched and the fetch pointer differs from the write pointer. The fetch address is the ring base plus the fetch pointer, both counted in dwords.
- R2: Pointers count dwords and wrap modulo 2^k, where k is ring control bits 5:1. A packet may straddle the end of the ring.
- R3: Opcode 0x3 (copy) is five words: header (bits 19:0 = byte count), destination bits 31:0, source bits 31:0, destination bits 39:32 in bits 7:0, source bits 39:32 in bits 7:0. It yields one `cp_valid` pulse with those values. Upper bits of the last two words are ignored.
- R4: Opcode 0x9 (register write) is three words. Word 2 holds byte enables in bits 19:16 and a dword register address in bits 15:0. Word 3 is the data. It yields one `rw_valid` pulse.
- R5: Opcode 0xF (no-op) is one word, produces no action and advances the read pointer by one.
- R6: Opcode 0x7 (trap) is one word. It pulses `trap_irq` only when engine control bit 0 is set. The value of that bit before any configuration write in the same cycle is the one that counts.
- R7: The decoder skips, with no output, opcode 0x2 (3 + count words), 0x4 (3 words), 0x5 (2 words), 0x6 (4 words) and 0xD (4 words).
- R8: Any other opcode sets `halted` and stops fetching, with the read pointer left on that header. Writing ring control with bit 0 clear clears `halted`.
- R9: The read pointer jumps past a packet only in the cycle its last word is consumed. A partly fetched packet leaves it unchanged.
- R10: When ring control bit 12 is set, `rptr_wb` pulses in the same cycle as each read-pointer update. Otherwise it stays low.
- R11: Configuration selects are 0 ring control, 1 base, 2 read pointer (accepted only while disabled; it also sets the fetch pointer), 3 write pointer and 4 engine control. After reset every register and every output is zero.
- R12: At most one of `cp_valid`, `rw_valid` and `trap_irq` is high in a cycle. Copy and register-write pulses never occur on two cycles in a row.
- R13: Disabling the ring drops any partly fetched packet and any outstanding read. After re-enabling, fetching restarts at the read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| rd_ptr | output | PTR_W | Committed read pointer (dwords) |
| halted | output | 1 | Sticky unknown-opcode flag |
| rptr_wb | output | 1 | Read-pointer writeback pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory dword address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cp_valid | output | 1 | Copy request pulse |
| cp_dst | output | 40 | Copy destination address |
| cp_src | output | 40 | Copy source address |
| cp_len | output | CNT_W | Copy byte count |
| rw_valid | output | 1 | Register write pulse |
| rw_addr | output | 16 | Register dword address |
| rw_be | output | 4 | Register byte enables |
| rw_data | output | 32 | Register write data |
| trap_irq | output | 1 | Trap interrupt pulse |

## Verification
Two events can land on the same clock edge: the decoder consuming a trap header, and software rewriting the engine control register that gates the trap. The bench forces this overlap from its memory model. It returns the trap word and, on that same edge, drives a configuration write that clears the trap enable. The bench expects exactly one interrupt, from the old enable value, and no interrupt for a second trap that follows.

// File: rtl/dma_ring_decoder.sv
module dma_ring_decoder #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              halted,
  output logic              rptr_wb,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              cp_valid,
  output logic [39:0]       cp_dst,
  output logic [39:0]       cp_src,
  output logic [CNT_W-1:0]  cp_len,
  output logic              rw_valid,
  output logic [15:0]       rw_addr,
  output logic [3:0]        rw_be,
  output logic [31:0]       rw_data,
  output logic              trap_irq
);
  localparam logic [2:0] SEL_RING = 3'd0;
  localparam logic [2:0] SEL_BASE = 3'd1;
  localparam logic [2:0] SEL_RPTR = 3'd2;
  localparam logic [2:0] SEL_WPTR = 3'd3;
  localparam logic [2:0] SEL_ENG  = 3'd4;
  localparam int LEN_W = CNT_W + 1;

  typedef enum logic {S_HDR, S_PAY} st_t;

  logic              ring_en, wb_en, trap_en;
  logic [4:0]        ring_lg;
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  wptr, fptr, fptr_nx, ptr_mask;
  logic              pend, drop;
  st_t               st;
  logic [3:0]        op;
  logic [CNT_W-1:0]  hcnt;
  logic [LEN_W-1:0]  rem, hlen;
  logic [2:0]        widx;
  logic [31:0]       w1, w2;
  logic [7:0]        w3;
  logic              dis_wr, take;

  function automatic logic [LEN_W-1:0] pkt_len(input logic [3:0] o, input logic [CNT_W-1:0] n);
    case (o)
      4'h2:    pkt_len = {1'b0, n} + LEN_W'(3);
      4'h3:    pkt_len = LEN_W'(5);
      4'h4:    pkt_len = LEN_W'(3);
      4'h5:    pkt_len = LEN_W'(2);
      4'h6:    pkt_len = LEN_W'(4);
      4'h7:    pkt_len = LEN_W'(1);
      4'h9:    pkt_len = LEN_W'(3);
      4'hD:    pkt_len = LEN_W'(4);
      4'hF:    pkt_len = LEN_W'(1);
      default: pkt_len = '0;
    endcase
  endfunction

  assign ptr_mask = ~({PTR_W{1'b1}} << ring_lg);
  assign fptr_nx  = (fptr + 1'b1) & ptr_mask;
  assign mem_req  = ring_en && !halted && !pend && (fptr != (wptr & ptr_mask));
  assign mem_addr = base + ADDR_W'(fptr);
  assign dis_wr   = cfg_we && (cfg_sel == SEL_RING) && !cfg_wdata[0];
  assign take     = mem_rvalid && pend && !drop && ring_en && !halted && !dis_wr;
  assign hlen     = pkt_len(mem_rdata[31:28], mem_rdata[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_en <= 1'b0; wb_en <= 1'b0; trap_en <= 1'b0; ring_lg <= '0;
      base <= '0; wptr <= '0; fptr <= '0; rd_ptr <= '0;
      pend <= 1'b0; drop <= 1'b0; halted <= 1'b0; st <= S_HDR;
      op <= '0; hcnt <= '0; rem <= '0; widx <= '0;
      w1 <= '0; w2 <= '0; w3 <= '0;
      rptr_wb <= 1'b0; cp_valid <= 1'b0; rw_valid <= 1'b0; trap_irq <= 1'b0;
      cp_dst <= '0; cp_src <= '0; cp_len <= '0;
      rw_addr <= '0; rw_be <= '0; rw_data <= '0;
    end else begin
      rptr_wb  <= 1'b0;
      cp_valid <= 1'b0;
      rw_valid <= 1'b0;
      trap_irq <= 1'b0;

      if (mem_req) pend <= 1'b1;
      else if (mem_rvalid && pend) begin
        pend <= 1'b0;
        drop <= 1'b0;
      end

      if (take) begin
        if (st == S_HDR) begin
          if (hlen == '0) begin
            halted <= 1'b1;
          end else if (hlen == LEN_W'(1)) begin
            fptr    <= fptr_nx;
            rd_ptr  <= fptr_nx;
            rptr_wb <= wb_en;
            if (mem_rdata[31:28] == 4'h7) trap_irq <= trap_en;
          end else begin
            fptr <= fptr_nx;
            st   <= S_PAY;
            op   <= mem_rdata[31:28];
            hcnt <= mem_rdata[CNT_W-1:0];
            rem  <= hlen - LEN_W'(1);
            widx <= 3'd1;
          end
        end else begin
          fptr <= fptr_nx;
          rem  <= rem - LEN_W'(1);
          if (widx != 3'd5) widx <= widx + 3'd1;
          case (widx)
            3'd1: w1 <= mem_rdata;
            3'd2: w2 <= mem_rdata;
            3'd3: w3 <= mem_rdata[7:0];
            default: ;
          endcase
          if (rem == LEN_W'(1)) begin
            st      <= S_HDR;
            rd_ptr  <= fptr_nx;
            rptr_wb <= wb_en;
            if (op == 4'h3) begin
              cp_valid <= 1'b1;
              cp_dst   <= {w3, w1};
              cp_src   <= {mem_rdata[7:0], w2};
              cp_len   <= hcnt;
            end
            if (op == 4'h9) begin
              rw_valid <= 1'b1;
              rw_be    <= w1[19:16];
              rw_addr  <= w1[15:0];
              rw_data  <= mem_rdata;
            end
          end
        end
      end

      if (cfg_we) begin
        case (cfg_sel)
          SEL_RING: begin
            ring_en <= cfg_wdata[0];
            ring_lg <= cfg_wdata[5:1];
            wb_en   <= cfg_wdata[12];
            if (!cfg_wdata[0]) begin
              st     <= S_HDR;
              fptr   <= rd_ptr;
              halted <= 1'b0;
              if ((pend && !mem_rvalid) || mem_req) drop <= 1'b1;
            end
          end
          SEL_BASE: base <= cfg_wdata[ADDR_W-1:0];
          SEL_RPTR: if (!ring_en) begin
            rd_ptr <= cfg_wdata[PTR_W-1:0];
            fptr   <= cfg_wdata[PTR_W-1:0];
          end
          SEL_WPTR: wptr <= cfg_wdata[PTR_W-1:0];
          SEL_ENG:  trap_en <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !(cfg_we && cfg_sel == SEL_RING) |=> halted); // R8
  AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R8
  AST_RPTR_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en && !(cfg_we && cfg_sel == SEL_RPTR) |=> $stable(rd_ptr)); // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cp_valid, rw_valid, trap_irq})); // R12
  AST_COPY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |=> !cp_valid); // R12
  AST_REGWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |=> !rw_valid); // R12
  AST_WB_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |=> !rptr_wb); // R10
endmodule

// File: tb/dma_ring_decoder_bench.sv
module dma_ring_decoder_bench;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [1:0]  kind;   // 1 copy, 2 regwrite, 3 trap
    logic [39:0] f1;
    logic [39:0] f2;
    logic [31:0] f3;
    logic [3:0]  f4;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [15:0] rd_ptr;
  logic halted, rptr_wb, mem_req, mem_rvalid, cp_valid, rw_valid, trap_irq;
  logic [31:0] mem_addr, mem_rdata, rw_data;
  logic [39:0] cp_dst, cp_src;
  logic [19:0] cp_len;
  logic [15:0] rw_addr;
  logic [3:0] rw_be;

  dma_ring_decoder u_dma_ring_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_ptr(rd_ptr), .halted(halted), .rptr_wb(rptr_wb),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cp_valid(cp_valid), .cp_dst(cp_dst), .cp_src(cp_src), .cp_len(cp_len),
    .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_be(rw_be), .rw_data(rw_data),
    .trap_irq(trap_irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int wb_cnt = 0, irq_cnt = 0;
  logic [31:0] mem [64];
  ev_t exp_q[$];
  int base_b = 0, sz = 32, wp = 0;
  logic hook_on = 0, hook_clr = 0;
  logic [31:0] hook_addr = 0;
  logic mon_on = 0;
  logic [15:0] prev_ptr = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one request outstanding, latency alternating 1 and 3
  initial begin : memmod
    logic [31:0] a;
    bit slow;
    slow = 0;
    mem_rvalid = 0;
    mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (hook_clr) begin cfg_we = 0; hook_clr = 0; end
      if (mem_req) begin
        a = mem_addr;
        repeat (slow ? 3 : 1) @(negedge clk);
        if (hook_clr) begin cfg_we = 0; hook_clr = 0; end
        slow = !slow;
        mem_rdata = mem[a[5:0]];
        mem_rvalid = 1;
        if (hook_on && a == hook_addr) begin
          cfg_sel = 3'd4; cfg_wdata = 0; cfg_we = 1;
          hook_on = 0; hook_clr = 1;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_on) begin
        ev_t got, want;
        if (rptr_wb) begin
          wb_cnt++;
          check(rd_ptr != prev_ptr, "R10 wb pulse with pointer move", rd_ptr, prev_ptr);
        end
        if (trap_irq) irq_cnt++;
        if ((int'(cp_valid) + int'(rw_valid) + int'(trap_irq)) > 1)
          check(0, "R12 two actions in one cycle", {cp_valid, rw_valid, trap_irq}, 0);
        got = '0;
        if (cp_valid) got = '{kind:2'd1, f1:cp_dst, f2:cp_src, f3:32'(cp_len), f4:4'd0};
        if (rw_valid) got = '{kind:2'd2, f1:40'(rw_addr), f2:40'd0, f3:rw_data, f4:rw_be};
        if (trap_irq) got = '{kind:2'd3, f1:40'd0, f2:40'd0, f3:32'd0, f4:4'd0};
        if (got.kind != 0) begin
          if (exp_q.size() == 0)
            check(0, got.kind == 3 ? "R6 unexpected trap" : "R3/R4/R7 unexpected action", got.kind, 0);
          else begin
            want = exp_q.pop_front();
            if (want.kind == 2'd1)
              check(got == want, "R3 copy fields", got[117:0], want[117:0]);
            else if (want.kind == 2'd2)
              check(got == want, "R4 register write fields", got[117:0], want[117:0]);
            else
              check(got == want, "R6 trap", got.kind, want.kind);
          end
        end
      end
      prev_ptr = rd_ptr;
    end
  end

  initial begin : watchdog
    #(CLK_NS * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(input int b, input int lg, input int start, input bit wb);
    cfg_write(3'd0, 32'd0);
    cfg_write(3'd1, 32'(b));
    cfg_write(3'd2, 32'(start));
    cfg_write(3'd3, 32'(start));
    cfg_write(3'd0, 32'(1 | (lg << 1) | (int'(wb) << 12)));
    base_b = b; sz = 1 << lg; wp = start;
  endtask

  task automatic put(input logic [31:0] w);
    mem[(base_b + wp) & 63] = w;
    wp = (wp + 1) % sz;
  endtask

  task automatic push_copy(input logic [39:0] d, input logic [39:0] s, input logic [19:0] n);
    exp_q.push_back('{kind:2'd1, f1:d, f2:s, f3:32'(n), f4:4'd0});
    put(32'h3400_0000 | 32'(n));
    put(d[31:0]);
    put(s[31:0]);
    put(32'hFFFF_FF00 | 32'(d[39:32]));
    put(32'h5A5A_5A00 | 32'(s[39:32]));
  endtask

  task automatic push_rw(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    exp_q.push_back('{kind:2'd2, f1:40'(a), f2:40'd0, f3:d, f4:be});
    put(32'hF9000000 & 32'h0000_0000 | 32'h9000_0000);
    put(32'hABC0_0000 | (32'(be) << 16) | 32'(a));
    put(d);
  endtask

  task automatic run_to(input int target, input string req);
    cfg_write(3'd3, 32'(wp));
    for (int i = 0; i < 400 && rd_ptr != 16'(target); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rd_ptr == 16'(target), req, rd_ptr, target);
    check(exp_q.size() == 0, {req, " all expected actions seen"}, exp_q.size(), 0);
  endtask

  initial begin : stim
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rd_ptr == 0, "R11 reset rd_ptr", rd_ptr, 0);
    check(!halted && !rptr_wb, "R11 reset flags", {halted, rptr_wb}, 0);
    check(!cp_valid && !rw_valid && !trap_irq, "R11 reset actions", {cp_valid, rw_valid, trap_irq}, 0);
    check(!mem_req, "R1 no fetch while disabled", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;

    // R3 copy, two patterns; R1 fetch from base
    setup(0, 5, 0, 0);
    push_copy(40'hA5_1234_5678, 40'h3C_0BAD_F00D, 20'h00400);
    push_copy(40'h01_0000_0004, 40'hFF_FFFF_FFF0, 20'hFFFFF);
    run_to(10, "R3 copy pair consumed");

    // R4 register write, R5 no-op padding
    push_rw(16'h0C1F, 4'h6, 32'hDEAD_BEEF);
    put(32'hF000_0000);
    put(32'hF000_0000);
    push_rw(16'hFFFF, 4'hF, 32'h0000_0001);
    run_to(18, "R4/R5 regwrite and no-op");

    // R7 skipped opcodes keep alignment
    put(32'h2000_0002); put(32'h3000_0010); put(32'h3000_0010); put(32'h9000_0000); put(32'h9000_0000);
    put(32'h4000_0000); put(32'h3000_0001); put(32'h3000_0001);
    put(32'h5000_0000); put(32'h3000_0001);
    put(32'h6000_0000); put(32'h3000_0001); put(32'h7000_0000); put(32'h9000_0000);
    put(32'hD000_0008); put(32'h3000_0001); put(32'h7000_0000); put(32'h9000_0000);
    push_rw(16'h0042, 4'h1, 32'h1357_9BDF);
    run_to(7, "R7 skip lengths then regwrite");

    // R2 wrap in a 16-dword ring at base 32
    setup(32, 4, 12, 0);
    push_copy(40'h77_0000_1000, 40'h88_0000_2000, 20'h00010);
    run_to(1, "R2 copy across ring end");

    // R6 trap gating
    setup(0, 5, 0, 0);
    cfg_write(3'd4, 32'd0);
    put(32'h7000_0000);
    run_to(1, "R6 trap disabled no irq");
    check(irq_cnt == 0, "R6 no irq when disabled", irq_cnt, 0);
    cfg_write(3'd4, 32'd1);
    exp_q.push_back('{kind:2'd3, f1:40'd0, f2:40'd0, f3:32'd0, f4:4'd0});
    put(32'h7000_0000);
    run_to(2, "R6 trap enabled");
    check(irq_cnt == 1, "R6 one irq when enabled", irq_cnt, 1);

    // R6 same-cycle: trap consumed while engine control is cleared
    hook_addr = 32'(base_b + wp);
    hook_on = 1;
    exp_q.push_back('{kind:2'd3, f1:40'd0, f2:40'd0, f3:32'd0, f4:4'd0});
    put(32'h7000_0000);
    put(32'h7000_0000);
    run_to(4, "R6 trap with same-cycle enable clear");
    check(irq_cnt == 2, "R6 old enable used, new enable blocks next", irq_cnt, 2);

    // R9 partial packet holds the read pointer
    setup(0, 5, 0, 0);
    push_copy(40'h12_3456_789A, 40'h00_0000_0040, 20'h00020);
    cfg_write(3'd3, 32'd3);
    repeat (40) @(negedge clk);
    check(rd_ptr == 0, "R9 partial packet no advance", rd_ptr, 0);
    check(exp_q.size() == 1, "R9 no action for partial packet", exp_q.size(), 1);

    // R13 disable drops partial packet, re-enable restarts at rd_ptr
    cfg_write(3'd0, 32'd0);
    cfg_write(3'd0, 32'(1 | (5 << 1)));
    run_to(5, "R9/R13 packet completes once after restart");

    // R8 unknown opcode halts
    setup(0, 5, 0, 0);
    put(32'hF000_0000); put(32'h1000_0000); put(32'hF000_0000);
    cfg_write(3'd3, 32'(wp));
    repeat (40) @(negedge clk);
    check(halted, "R8 halted set", halted, 1);
    check(rd_ptr == 1, "R8 rd_ptr stays on bad header", rd_ptr, 1);
    check(!mem_req, "R8 no fetch while halted", mem_req, 0);
    cfg_write(3'd0, 32'd0);
    @(negedge clk);
    check(!halted, "R8 cleared by disable", halted, 0);

    // R10 writeback pulses
    check(wb_cnt == 0, "R10 no wb when disabled bit", wb_cnt, 0);
    setup(0, 5, 0, 1);
    put(32'hF000_0000); put(32'hF000_0000);
    push_rw(16'h0003, 4'h8, 32'hCAFE_0001);
    run_to(5, "R10 pointer after wb run");
    check(wb_cnt == 3, "R10 one wb per packet", wb_cnt, 3);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule